// File: doc/BRIEF.md
# Snoop Response Collector and Line Merger

This block tracks one in-flight DMA transaction at a coherence home node. When a DMA read or write is accepted, the block is allocated with the line's byte offset, the number of bytes the DMA covers and the DMA write bytes. It then expects exactly one snoop response from every last-level cache. It counts those responses down, notes whether any cache still holds a shared copy, and decides which copy of the line is authoritative. A data response from a cache always beats the copy from memory, whatever order they arrive in.

When the last expected response has been counted, the block raises a one-cycle completion pulse together with a flag that says whether sharers remain. The selected line is always visible on an output. A second output shows that line with the DMA write bytes laid over it, ready to be written back to memory. A response that arrives when no response is outstanding raises a one-cycle error pulse. Sequencing of the transaction and the network interfaces belong to the surrounding controller.

Top module: `snp_collector`

## Requirements
- R1: An allocate cycle loads the outstanding count with NUM_CACHES, clears the dirty flag, the sharer flag and the held line to all zeros, and latches offset, length and write bytes. A response or memory beat in the same cycle as an allocate is discarded.
- R2: Each accepted response lowers the outstanding count by exactly one, whatever its kind. Kind encoding: 0 = plain ack, 1 = shared ack, 2 = shared data, 3 = exclusive data.
- R3: A response of kind 1 or 2 marks that sharers exist. Kinds 0 and 3 leave that mark unchanged.
- R4: The response that brings the count from one to zero causes `done_pulse` high for exactly the following cycle. At the same time, `done_sharers` is 1 if any response of the transaction (including the last one) was of kind 1 or 2, and 0 otherwise.
- R5: A response of kind 2 or 3 replaces the held line with its data and sets the dirty flag. While the dirty flag is set, memory data has no effect on the held line. When cache data and memory data arrive in the same cycle, the cache data is kept.
- R6: Memory data arriving while the dirty flag is clear, outside an allocate cycle, replaces the held line. A later beat replaces an earlier one.
- R7: A response arriving when the count is already zero, outside an allocate cycle, gives `err_pulse` high for exactly the following cycle and changes neither the count nor the held line.
- R8: `merged_line` equals the held line, except that byte i (bits 8i+7..8i) is taken from byte i of the latched write data for offset <= i < offset+length. Length is 1 to LINE_BYTES-offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Start tracking a new transaction |
| alloc_byte_off | input | OFF_W (6) | Byte offset of the DMA access in the line |
| alloc_len | input | OFF_W+1 (7) | Number of DMA bytes |
| alloc_wdata | input | LINE_W (512) | Line-aligned DMA write bytes |
| rsp_valid | input | 1 | A cache snoop response is present |
| rsp_kind | input | 2 | Response kind, encoded as in R2 |
| rsp_data | input | LINE_W (512) | Line carried by data responses |
| mem_valid | input | 1 | Memory read data is present |
| mem_data | input | LINE_W (512) | Line read from memory |
| done_pulse | output | 1 | All responses received (one cycle) |
| done_sharers | output | 1 | Sharers remain; valid with done_pulse |
| line_data | output | LINE_W (512) | Currently authoritative line |
| merged_line | output | LINE_W (512) | Held line with DMA bytes overlaid |
| err_pulse | output | 1 | Response arrived while nothing was outstanding |

## Verification
The assertions assume that an allocate is never held for two cycles in a row. They also assume that the length and offset together never point past the end of the line, and that the controller drives `rsp_kind` only with the four defined codes. The bench drives every input for exactly one cycle between falling edges and keeps every length within the bytes left after its offset. It sends unexpected responses only on purpose, to exercise the error path.

// File: rtl/snp_pkg.sv
package snp_pkg;

  typedef enum logic [1:0] {
    RSP_ACK     = 2'd0,
    RSP_SH_ACK  = 2'd1,
    RSP_SH_DATA = 2'd2,
    RSP_EX_DATA = 2'd3
  } rsp_kind_e;

  function automatic logic kind_has_data(input rsp_kind_e k);
    return (k == RSP_SH_DATA) || (k == RSP_EX_DATA);
  endfunction

  function automatic logic kind_is_shared(input rsp_kind_e k);
    return (k == RSP_SH_ACK) || (k == RSP_SH_DATA);
  endfunction

  // true when byte index idx lies in the DMA window [off, off+len)
  function automatic logic byte_in_window(input int idx, input int off, input int len);
    return (idx >= off) && (idx < off + len);
  endfunction

endpackage

// File: rtl/snp_tally.sv
module snp_tally #(
  parameter int NUM_CACHES = 4,
  localparam int CNT_W = $clog2(NUM_CACHES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             rsp_valid,
  input  logic [1:0]       rsp_kind,
  output logic [CNT_W-1:0] pending,
  output logic             rsp_live,
  output logic             done_pulse,
  output logic             done_sharers,
  output logic             err_pulse
);
  import snp_pkg::*;

  logic sharer_q;
  logic shared_now;
  logic stray;

  assign rsp_live   = rsp_valid && !alloc_valid && (pending != '0);
  assign stray      = rsp_valid && !alloc_valid && (pending == '0);
  assign shared_now = kind_is_shared(rsp_kind_e'(rsp_kind));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending      <= '0;
      sharer_q     <= 1'b0;
      done_pulse   <= 1'b0;
      done_sharers <= 1'b0;
      err_pulse    <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      err_pulse  <= stray;
      if (alloc_valid) begin
        pending  <= CNT_W'(NUM_CACHES);
        sharer_q <= 1'b0;
      end else if (rsp_live) begin
        pending <= pending - 1'b1;
        if (shared_now) sharer_q <= 1'b1;
        if (pending == CNT_W'(1)) begin
          done_pulse   <= 1'b1;
          done_sharers <= sharer_q | shared_now;
        end
      end
    end
  end

endmodule

// File: rtl/snp_line_sel.sv
module snp_line_sel #(
  parameter int LINE_W = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              rsp_live,
  input  logic [1:0]        rsp_kind,
  input  logic [LINE_W-1:0] rsp_data,
  input  logic              mem_valid,
  input  logic [LINE_W-1:0] mem_data,
  output logic [LINE_W-1:0] line_q,
  output logic              dirty_q
);
  import snp_pkg::*;

  logic take_cache;
  logic take_mem;

  assign take_cache = rsp_live && kind_has_data(rsp_kind_e'(rsp_kind));
  assign take_mem   = mem_valid && !alloc_valid && !dirty_q && !take_cache;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= '0;
      dirty_q <= 1'b0;
    end else if (alloc_valid) begin
      line_q  <= '0;
      dirty_q <= 1'b0;
    end else if (take_cache) begin
      line_q  <= rsp_data;
      dirty_q <= 1'b1;
    end else if (take_mem) begin
      line_q  <= mem_data;
    end
  end

endmodule

// File: rtl/snp_byte_merge.sv
module snp_byte_merge #(
  parameter int LINE_BYTES = 64,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES)
) (
  input  logic [LINE_W-1:0] base_line,
  input  logic [LINE_W-1:0] dma_bytes,
  input  logic [OFF_W-1:0]  off,
  input  logic [OFF_W:0]    len,
  output logic [LINE_W-1:0] merged
);
  import snp_pkg::*;

  for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
    logic sel;
    assign sel = byte_in_window(b, int'(off), int'(len));
    assign merged[b*8 +: 8] = sel ? dma_bytes[b*8 +: 8] : base_line[b*8 +: 8];
  end

endmodule

// File: rtl/snp_collector.sv
module snp_collector #(
  parameter int NUM_CACHES = 4,
  parameter int LINE_BYTES = 64,
  localparam int LINE_W = LINE_BYTES * 8,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int CNT_W  = $clog2(NUM_CACHES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [OFF_W-1:0]  alloc_byte_off,
  input  logic [OFF_W:0]    alloc_len,
  input  logic [LINE_W-1:0] alloc_wdata,
  input  logic              rsp_valid,
  input  logic [1:0]        rsp_kind,
  input  logic [LINE_W-1:0] rsp_data,
  input  logic              mem_valid,
  input  logic [LINE_W-1:0] mem_data,
  output logic              done_pulse,
  output logic              done_sharers,
  output logic [LINE_W-1:0] line_data,
  output logic [LINE_W-1:0] merged_line,
  output logic              err_pulse
);

  logic [CNT_W-1:0]  pending;
  logic              rsp_live;
  logic              dirty;
  logic [OFF_W-1:0]  off_q;
  logic [OFF_W:0]    len_q;
  logic [LINE_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (alloc_valid) begin
      off_q   <= alloc_byte_off;
      len_q   <= alloc_len;
      wdata_q <= alloc_wdata;
    end
  end

  snp_tally #(.NUM_CACHES(NUM_CACHES)) tally_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .alloc_valid  (alloc_valid),
    .rsp_valid    (rsp_valid),
    .rsp_kind     (rsp_kind),
    .pending      (pending),
    .rsp_live     (rsp_live),
    .done_pulse   (done_pulse),
    .done_sharers (done_sharers),
    .err_pulse    (err_pulse)
  );

  snp_line_sel #(.LINE_W(LINE_W)) sel_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .alloc_valid (alloc_valid),
    .rsp_live    (rsp_live),
    .rsp_kind    (rsp_kind),
    .rsp_data    (rsp_data),
    .mem_valid   (mem_valid),
    .mem_data    (mem_data),
    .line_q      (line_data),
    .dirty_q     (dirty)
  );

  snp_byte_merge #(.LINE_BYTES(LINE_BYTES)) merge_i (
    .base_line (line_data),
    .dma_bytes (wdata_q),
    .off       (off_q),
    .len       (len_q),
    .merged    (merged_line)
  );

endmodule

// File: rtl/snp_collector_chk.sv
module snp_collector_chk #(
  parameter int NUM_CACHES = 4,
  parameter int LINE_W = 512,
  localparam int CNT_W = $clog2(NUM_CACHES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              alloc_valid,
  input logic              rsp_valid,
  input logic              mem_valid,
  input logic [CNT_W-1:0]  pending,
  input logic              dirty,
  input logic [LINE_W-1:0] line_data,
  input logic              done_pulse,
  input logic              err_pulse
);

  p_alloc_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> (pending == CNT_W'(NUM_CACHES)) && !dirty && (line_data == '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !alloc_valid && pending != '0) |=> (pending == $past(pending) - 1'b1));

  p_done_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !alloc_valid && pending == CNT_W'(1)) |=> done_pulse);

  p_done_only_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (pending == '0) || $past(alloc_valid));

  p_mem_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dirty && mem_valid && !rsp_valid && !alloc_valid) |=> $stable(line_data));

  p_stray_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !alloc_valid && pending == '0) |=> err_pulse && (pending == '0));

endmodule

bind snp_collector snp_collector_chk #(.NUM_CACHES(NUM_CACHES), .LINE_W(LINE_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_valid (alloc_valid),
  .rsp_valid   (rsp_valid),
  .mem_valid   (mem_valid),
  .pending     (pending),
  .dirty       (dirty),
  .line_data   (line_data),
  .done_pulse  (done_pulse),
  .err_pulse   (err_pulse)
);

// File: tb/snp_collector_tb_top.sv
module snp_collector_tb_top;
  localparam int NC = 4;
  localparam int LB = 64;
  localparam int LW = LB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 1'b0;
  logic [5:0] alloc_byte_off = '0;
  logic [6:0] alloc_len = '0;
  logic [LW-1:0] alloc_wdata = '0;
  logic rsp_valid = 1'b0;
  logic [1:0] rsp_kind = '0;
  logic [LW-1:0] rsp_data = '0;
  logic mem_valid = 1'b0;
  logic [LW-1:0] mem_data = '0;
  logic done_pulse, done_sharers, err_pulse;
  logic [LW-1:0] line_data, merged_line;

  int checks = 0;
  int failures = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  snp_collector #(.NUM_CACHES(NC), .LINE_BYTES(LB)) dut_i (.*);

  function automatic logic [LW-1:0] pat(input int seed);
    logic [LW-1:0] v;
    for (int b = 0; b < LB; b++) v[b*8 +: 8] = 8'(seed + b * 7 + 3);
    return v;
  endfunction

  function automatic logic [LW-1:0] overlay(input logic [LW-1:0] base, input logic [LW-1:0] w,
                                            input int off, input int len);
    logic [LW-1:0] v;
    v = base;
    for (int b = off; b < off + len; b++) v[b*8 +: 8] = w[b*8 +: 8];
    return v;
  endfunction

  task automatic chk(input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic alloc(input int off, input int len, input logic [LW-1:0] w);
    alloc_valid = 1; alloc_byte_off = 6'(off); alloc_len = 7'(len); alloc_wdata = w;
    @(negedge clk);
    alloc_valid = 0;
  endtask

  task automatic rsp(input logic [1:0] k, input logic [LW-1:0] d);
    rsp_valid = 1; rsp_kind = k; rsp_data = d;
    @(negedge clk);
    rsp_valid = 0;
  endtask

  task automatic mem(input logic [LW-1:0] d);
    mem_valid = 1; mem_data = d;
    @(negedge clk);
    mem_valid = 0;
  endtask

  task automatic t_reset;
    chk("R1 reset done", LW'(done_pulse), '0);
    chk("R7 reset err", LW'(err_pulse), '0);
    chk("R1 reset line", line_data, '0);
  endtask

  task automatic t_clean_read;
    alloc(0, 64, pat(1));
    chk("R1 line cleared", line_data, '0);
    mem(pat(10));
    chk("R6 mem captured", line_data, pat(10));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R2 no early done", LW'(done_pulse), '0);
    rsp(2'd0, pat(99));
    chk("R4 done", LW'(done_pulse), 1);
    chk("R4 no sharers", LW'(done_sharers), 0);
    chk("R2 ack data ignored", line_data, pat(10));
    @(negedge clk);
    chk("R4 single pulse", LW'(done_pulse), 0);
  endtask

  task automatic t_shared_ack;
    alloc(0, 64, pat(2));
    rsp(2'd1, '0); rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R3 shared ack done", LW'(done_pulse), 1);
    chk("R3 sharers flagged", LW'(done_sharers), 1);
    alloc(0, 64, pat(2));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd3, pat(5)); rsp(2'd1, '0);
    chk("R4 last shared tags", LW'(done_sharers), 1);
  endtask

  task automatic t_cache_first;
    alloc(0, 64, pat(3));
    rsp(2'd3, pat(20));
    mem(pat(21));
    chk("R5 mem after cache ignored", line_data, pat(20));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R4 excl no sharers", LW'(done_sharers), 0);
    chk("R4 excl done", LW'(done_pulse), 1);
  endtask

  task automatic t_mem_first;
    alloc(0, 64, pat(4));
    mem(pat(30));
    mem(pat(31));
    chk("R6 later mem wins", line_data, pat(31));
    rsp(2'd2, pat(32));
    chk("R5 cache overrides mem", line_data, pat(32));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R3 shared data sharers", LW'(done_sharers), 1);
  endtask

  task automatic t_same_cycle;
    alloc(0, 64, pat(5));
    rsp_valid = 1; rsp_kind = 2'd3; rsp_data = pat(40);
    mem_valid = 1; mem_data = pat(41);
    @(negedge clk);
    rsp_valid = 0; mem_valid = 0;
    chk("R5 same cycle cache wins", line_data, pat(40));
  endtask

  task automatic t_stray;
    alloc(0, 64, pat(6));
    mem(pat(50));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R7 no err on last", LW'(err_pulse), 0);
    rsp(2'd3, pat(51));
    chk("R7 stray err", LW'(err_pulse), 1);
    chk("R7 stray line kept", line_data, pat(50));
    chk("R7 no done on stray", LW'(done_pulse), 0);
    @(negedge clk);
    chk("R7 err one cycle", LW'(err_pulse), 0);
  endtask

  task automatic t_alloc_priority;
    alloc(0, 64, pat(7));
    rsp(2'd3, pat(60));
    alloc_valid = 1; alloc_byte_off = 0; alloc_len = 64; alloc_wdata = pat(7);
    rsp_valid = 1; rsp_kind = 2'd2; rsp_data = pat(61);
    @(negedge clk);
    alloc_valid = 0; rsp_valid = 0;
    chk("R1 realloc clears line", line_data, '0);
    mem(pat(62));
    chk("R1 dirty cleared", line_data, pat(62));
    rsp(2'd0, '0); rsp(2'd0, '0); rsp(2'd0, '0);
    chk("R1 count reloaded", LW'(done_pulse), 0);
    rsp(2'd0, '0);
    chk("R1 done after full count", LW'(done_pulse), 1);
    chk("R1 sharer cleared", LW'(done_sharers), 0);
  endtask

  task automatic t_merge(input int off, input int len, input int seed);
    alloc(off, len, pat(seed));
    mem(pat(seed + 100));
    chk($sformatf("R8 merge off=%0d len=%0d", off, len), merged_line,
        overlay(pat(seed + 100), pat(seed), off, len));
  endtask

  task automatic t_merge_cache;
    alloc(10, 4, pat(77));
    rsp(2'd3, pat(78));
    mem(pat(79));
    chk("R8 merge over cache line", merged_line, overlay(pat(78), pat(77), 10, 4));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_clean_read;
    t_shared_ack;
    t_cache_first;
    t_mem_first;
    t_same_cycle;
    t_stray;
    t_alloc_priority;
    t_merge(5, 3, 11);
    t_merge(0, 64, 12);
    t_merge(63, 1, 13);
    t_merge(32, 32, 14);
    t_merge_cache;
    if (!ended) begin
      ended = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule